// File: doc/BRIEF.md
# Audio Frame Clock Generator

This block produces the left/right frame clock for an audio serial port acting as clock master. The frame clock is derived from the prescaled master clock, which is the only clock the block sees. A 4-bit rate code picks one of two paths. Code zero selects a fractional divider: a phase accumulator adds a 16-bit step word on every clock, modulo 96 × 65536. Codes 8 to 15 select fixed clock-to-frame ratios, one of which is a half-integer ratio.

A one-cycle strobe marks the start of each frame, which is the rising edge of the frame clock. A new rate code or step word is adopted only when the current frame ends, so the frame clock never shows a torn period. The error flag combines two conditions. It covers the reserved codes. It also covers step words that would push the frame rate above the ceiling allowed for voice operation. That ceiling is evaluated against a prescaled clock frequency set by a parameter.

Top module: `lrclk_gen`

## Requirements
- R1: After reset, and from the cycle after `en` is sampled low, `lrclk` and `frame_start` are 0.
- R2: With `mode` = 0, the frame period is 6291456 / `div_word` clock cycles when that ratio is an integer: 0x6000 gives 256 cycles with 128 high, and 0x4000 gives 384 cycles with 192 high.
- R3: With `mode` = 0, in cycle t of a run that starts at t = 0, `lrclk` is 1 exactly when (t × `div_word`) mod 6291456 is below 3145728.
- R4: Codes 0x8, 0x9, 0xA, 0xC, 0xD, 0xE and 0xF give frames of 1500, 750, 1625, 2000, 1000, 2400 and 1200 cycles. `lrclk` is high for the first floor(length/2) cycles of each frame.
- R5: Code 0xB alternates frames of 812 and 813 cycles, starting with 812, and is high for 406 cycles in each frame.
- R6: Bit 0 of `div_word` counts in the step like any other bit, so an odd step word keeps the frame timing of R3.
- R7: `cfg_err` is 1 when `voice` is 1, `mode` is 0 and `div_word` is above 0x3000, the 24 kHz limit at the default 12.288 MHz prescaled clock. It is 0 for a step word of 0x3000 or less, when `voice` is 0, and for codes 8 to 15.
- R8: Codes 0x1 to 0x7 set `cfg_err` in the same cycle. Once such a code is adopted, `lrclk` stays 0, and the next valid code is adopted one cycle later.
- R9: `frame_start` is 1 for exactly one cycle, on each cycle where `lrclk` goes from 0 to 1.
- R10: A change of `mode` or `div_word` made during a frame does not alter that frame. The new setting applies from the next frame, including a change made in the last cycle of a frame.
- R11: After `en` returns high, the first running cycle is the start of a frame at phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears the frame state |
| mode | input | 4 | Rate code: 0 fractional, 1-7 reserved, 8-15 fixed ratios |
| div_word | input | DIV_W (16) | Accumulator step for fractional mode |
| voice | input | 1 | Voice operation, limits frame rate |
| lrclk | output | 1 | Frame clock |
| frame_start | output | 1 | One-cycle strobe at each frame start |
| cfg_err | output | 1 | Reserved code or rate too high for voice |

## Verification
The frame boundary and the adoption of new settings can fall in the same cycle. The bench provokes this by changing the step word in the very last cycle of a 256-cycle frame, and then changing the rate code in the middle of a fixed-ratio frame. It judges the outcome by the exact cycles of later frame-start strobes. A second coincidence is an enable drop during a running frame, which is judged by the frame clock going low one cycle later.

// File: rtl/lrclk_gen.sv
`timescale 1ns/1ps
module lrclk_gen #(
  parameter int DIV_W = 16,
  parameter longint PCLK_HZ = 12_288_000,
  parameter longint VOICE_MAX_HZ = 24_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       mode,
  input  logic [DIV_W-1:0] div_word,
  input  logic             voice,
  output logic             lrclk,
  output logic             frame_start,
  output logic             cfg_err
);
  localparam longint MODULUS = 64'd96 << DIV_W;
  localparam int ACC_W = $clog2(MODULUS);
  localparam int CNT_W = 12;
  localparam logic [ACC_W:0] MOD_V = (ACC_W+1)'(MODULUS);
  localparam logic [ACC_W-1:0] HALF_V = ACC_W'(MODULUS / 2);
  localparam longint NI_LIMIT = (VOICE_MAX_HZ * MODULUS) / PCLK_HZ;

  function automatic logic [CNT_W-1:0] frame_len(input logic [3:0] m, input logic o);
    case (m)
      4'h8: frame_len = CNT_W'(1500);
      4'h9: frame_len = CNT_W'(750);
      4'hA: frame_len = CNT_W'(1625);
      4'hB: frame_len = o ? CNT_W'(813) : CNT_W'(812);
      4'hC: frame_len = CNT_W'(2000);
      4'hD: frame_len = CNT_W'(1000);
      4'hE: frame_len = CNT_W'(2400);
      4'hF: frame_len = CNT_W'(1200);
      default: frame_len = CNT_W'(1);
    endcase
  endfunction

  logic             run, odd, lr_q;
  logic [3:0]       cur_mode;
  logic [DIV_W-1:0] cur_div;
  logic [ACC_W-1:0] acc, acc_nx;
  logic [CNT_W-1:0] pos, len;
  logic [ACC_W:0]   sum;
  logic             is_norm, is_int, wrap, bnd, phase_hi;

  assign is_norm  = (cur_mode == 4'h0);
  assign is_int   = cur_mode[3];
  assign len      = frame_len(cur_mode, odd);
  assign sum      = {1'b0, acc} + (ACC_W+1)'(cur_div);
  assign wrap     = (sum >= MOD_V);
  assign acc_nx   = wrap ? ACC_W'(sum - MOD_V) : sum[ACC_W-1:0];
  assign bnd      = is_norm ? wrap : (is_int ? (pos == len - CNT_W'(1)) : 1'b1);
  assign phase_hi = is_norm ? (acc < HALF_V) : (is_int ? (pos < (len >> 1)) : 1'b0);

  assign lrclk       = run & phase_hi;
  assign frame_start = lrclk & ~lr_q;
  assign cfg_err     = (mode != 4'h0 && !mode[3]) ||
                       (voice && mode == 4'h0 && longint'(div_word) > NI_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; odd <= 1'b0; lr_q <= 1'b0;
      cur_mode <= '0; cur_div <= '0; acc <= '0; pos <= '0;
    end else begin
      lr_q <= lrclk;
      if (!en || !run) begin
        run <= en; cur_mode <= mode; cur_div <= div_word;
        acc <= '0; pos <= '0; odd <= 1'b0;
      end else if (bnd) begin
        cur_mode <= mode; cur_div <= div_word; pos <= '0;
        acc <= (is_norm && mode == 4'h0) ? acc_nx : '0;
        odd <= (cur_mode == 4'hB && mode == 4'hB) ? ~odd : 1'b0;
      end else begin
        if (is_norm) acc <= acc_nx;
        if (is_int) pos <= pos + CNT_W'(1);
      end
    end
  end

  AST_IDLE_LOW:      assert property (@(posedge clk) disable iff (!rst_n) !en |=> !lrclk); // R1
  AST_ACC_RANGE:     assert property (@(posedge clk) disable iff (!rst_n) {1'b0, acc} < MOD_V); // R3
  AST_POS_RANGE:     assert property (@(posedge clk) disable iff (!rst_n) (run && is_int) |-> pos < len); // R4
  AST_ODD_ONLY_B:    assert property (@(posedge clk) disable iff (!rst_n) odd |-> cur_mode == 4'hB); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start); // R9
endmodule

// File: tb/lrclk_gen_tb_top.sv
`timescale 1ns/1ps
module lrclk_gen_tb_top;
  localparam longint MODULUS = 6291456;
  localparam longint HALF = 3145728;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, voice = 1'b0;
  logic [3:0] mode = 4'h0;
  logic [15:0] div_word = 16'h0;
  logic lrclk, frame_start, cfg_err;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lrclk_gen dut_i (.clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .div_word(div_word),
                   .voice(voice), .lrclk(lrclk), .frame_start(frame_start), .cfg_err(cfg_err));

  function automatic int ref_len(input logic [3:0] m, input bit o);
    case (m)
      4'h8: return 1500;  4'h9: return 750;  4'hA: return 1625;
      4'hB: return o ? 813 : 812;
      4'hC: return 2000;  4'hD: return 1000; 4'hE: return 2400;
      default: return 1200;
    endcase
  endfunction

  task automatic tally(input string tag, input bit ok, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [3:0] m, input logic [15:0] d);
    @(negedge clk); en = 1'b0; voice = 1'b0;
    repeat (2) @(negedge clk);
    mode = m; div_word = d; en = 1'b1;
  endtask

  task automatic run_normal(input logic [15:0] d, input int ncyc, input string tag);
    bit prev = 0, bad = 0;
    longint a = 0, e = 0;
    start(4'h0, d);
    for (int t = 0; t < ncyc; t++) begin
      bit elr, efs;
      @(negedge clk);
      elr = ((longint'(t) * d) % MODULUS) < HALF;
      efs = elr && !prev;
      prev = elr;
      if (!bad && (lrclk !== elr || frame_start !== efs)) begin
        bad = 1; a = {lrclk, frame_start}; e = {elr, efs};
        $display("  mismatch at t=%0d div=%h", t, d);
      end
    end
    tally(tag, !bad, a, e);
  endtask

  task automatic run_int(input logic [3:0] c, input int ncyc, input string tag);
    int p = 0, l;
    bit o = 0, bad = 0;
    longint a = 0, e = 0;
    l = ref_len(c, 0);
    start(c, 16'h0);
    for (int t = 0; t < ncyc; t++) begin
      bit elr, efs;
      @(negedge clk);
      elr = p < (l / 2);
      efs = (p == 0);
      if (!bad && (lrclk !== elr || frame_start !== efs)) begin
        bad = 1; a = {lrclk, frame_start}; e = {elr, efs};
        $display("  mismatch at t=%0d code=%h", t, c);
      end
      p++;
      if (p == l) begin p = 0; if (c == 4'hB) o = !o; l = ref_len(c, o); end
    end
    tally(tag, !bad, a, e);
  endtask

  task automatic check_starts(input int ncyc, input int chg_t, input logic [3:0] m2,
                              input logic [15:0] d2, input int exp_fs[4], input string tag);
    int idx = 0;
    bit bad = 0;
    longint a = -1, e = -1;
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      if (frame_start) begin
        if (idx >= 4 || exp_fs[idx] != t) begin
          if (!bad) begin a = t; e = (idx < 4) ? exp_fs[idx] : -1; end
          bad = 1;
        end
        idx++;
      end
      if (t == chg_t) begin mode = m2; div_word = d2; end
    end
    if (!bad && idx != 4) begin bad = 1; a = idx; e = 4; end
    tally(tag, !bad, a, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tally("R1 reset lrclk", lrclk === 1'b0 && frame_start === 1'b0, {lrclk, frame_start}, 0);

    run_normal(16'h6000, 800, "R2 div 0x6000 period 256");
    run_normal(16'h4000, 1200, "R2 div 0x4000 period 384");
    run_normal(16'h6001, 26000, "R6 rapid-lock bit set");
    for (int i = 0; i < 10; i++) begin
      logic [15:0] d;
      d = 16'($urandom_range(16'hFFFF, 16'h0800));
      run_normal(d, 2000, "R3 random divider");
    end

    for (int c = 8; c < 16; c++) begin
      if (c != 11) run_int(4'(c), 2 * ref_len(4'(c), 0) + 300, "R4 integer ratio");
    end
    run_int(4'hB, 3300, "R5 alternating 812/813");
    for (int i = 0; i < 3; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(15, 8));
      run_int(c, 2600, "R4 random integer code");
    end

    start(4'hC, 16'h0);
    check_starts(4500, 500, 4'hD, 16'h0, '{0, 2000, 3000, 4000}, "R10 mode change mid-frame");
    start(4'h0, 16'h6000);
    check_starts(1100, 255, 4'h0, 16'h4000, '{0, 256, 640, 1024}, "R10 divider change at frame end");
    start(4'h0, 16'h6000);
    check_starts(1100, 100, 4'h0, 16'h4000, '{0, 256, 640, 1024}, "R9 strobe positions after change");

    start(4'hC, 16'h0);
    for (int t = 0; t <= 3001; t++) begin
      @(negedge clk);
      if (t == 11) tally("R8 reserved code flags error", cfg_err === 1'b1, cfg_err, 1);
      if (t == 500) tally("R10 old frame continues", lrclk === 1'b1, lrclk, 1);
      if (t == 2500) tally("R8 reserved holds lrclk low", lrclk === 1'b0 && frame_start === 1'b0, lrclk, 0);
      if (t == 3001) tally("R8 valid code adopted next cycle", lrclk === 1'b1 && frame_start === 1'b1, {lrclk, frame_start}, 3);
      if (t == 10) mode = 4'h3;
      if (t == 3000) mode = 4'hD;
    end

    start(4'h0, 16'h6000);
    for (int t = 0; t < 53; t++) begin
      @(negedge clk);
      if (t == 51) tally("R1 enable low clears lrclk", lrclk === 1'b0 && frame_start === 1'b0, {lrclk, frame_start}, 0);
      if (t == 50) en = 1'b0;
    end
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    tally("R11 restart at phase zero", lrclk === 1'b1 && frame_start === 1'b1, {lrclk, frame_start}, 3);

    @(negedge clk); en = 1'b0; mode = 4'h0; voice = 1'b1; div_word = 16'h3001; #1;
    tally("R7 voice above limit", cfg_err === 1'b1, cfg_err, 1);
    div_word = 16'h3000; #1;
    tally("R7 voice at limit", cfg_err === 1'b0, cfg_err, 0);
    voice = 1'b0; div_word = 16'h6000; #1;
    tally("R7 stereo high rate", cfg_err === 1'b0, cfg_err, 0);
    voice = 1'b1; mode = 4'h9; #1;
    tally("R7 integer code no error", cfg_err === 1'b0, cfg_err, 0);
    voice = 1'b0; mode = 4'h5; #1;
    tally("R8 reserved code 5", cfg_err === 1'b1, cfg_err, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule